// File: doc/BRIEF.md
# Serial ROM Boot Loader

The block fills the top 64 bytes of a 16-bit memory space from a serial flash or EEPROM while the processor is kept off the bus. After a start pulse it drops chip select and clocks out a read opcode with a 24-bit ROM address, most significant bit first, in SPI mode 0. It then clocks in the returned stream without counting bytes. The stream is a series of self-addressed byte pairs. The first byte of a pair holds a frame flag in bit 7, an end flag in bit 6 and the low six address bits. The second byte is the data.

Incoming bits enter a 16-bit chain made of an address byte followed by a data byte. The chain is cleared at start and after every accepted write. While the opcode and address go out, the ROM output line reads as zero, so the chain stays empty. A write is offered only when the frame flag reaches the head of the chain. Each write goes out as a valid/ready transfer. The address has bits 15..6 forced to one, and the data byte comes from the pair. A pair whose end flag is set is written like any other. The loader then releases chip select, stops the serial clock, raises the done flag and enables the processor bus.

Top module: `boot_loader`

## Requirements
- R1: While reset is held, and after reset is released until a start pulse arrives, spi_cs_n is 1, spi_sclk is 0, mem_wr is 0, load_done is 0 and cpu_bus_en is 0.
- R2: After start, spi_cs_n goes low. The first 32 bits clocked out on spi_mosi are the 8-bit opcode READ_CMD followed by the 24-bit ROM_BASE, MSB first, each one stable on the rising spi_sclk edge and changing only on the falling edge. After these 32 bits, spi_mosi stays 0.
- R3: spi_miso is sampled on every rising spi_sclk edge into the 16-bit chain. A serial line that stays at 0 never produces a write, and the loader keeps running.
- R4: When a 1 in bit 7 of an address byte has moved to the head of the chain, the loader offers one write. Any number of 0 bits may come before the address byte. The write uses address byte bits 5..0 and the following data byte, and writes are offered in stream order.
- R5: mem_addr[15:6] is all ones on every write, so every write lands in 16'hFFC0..16'hFFFF.
- R6: Back-pressure: mem_wr (valid) stays high with mem_addr and mem_data unchanged until mem_ready is high on a clock edge, which completes exactly one transfer. spi_sclk does not change while the write waits.
- R7: After each accepted write the chain is cleared. The next pair is assembled from the bits that follow, so zero gaps of any length between pairs are allowed.
- R8: A pair whose address byte has bit 6 set is written, and on acceptance spi_cs_n goes to 1, spi_sclk to 0, and load_done and cpu_bus_en to 1. These values then hold, and bits after that pair cause no write.
- R9: A start pulse is ignored unless the loader is idle. A start during a load or after completion does not restart the sequence and does not change the writes.
- R10: spi_sclk has a period of 2*DIV system clocks while the loader runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; acted on only when idle |
| spi_sclk | output | 1 | Serial clock to the ROM (mode 0) |
| spi_cs_n | output | 1 | ROM chip select, active low |
| spi_mosi | output | 1 | Opcode and address to the ROM |
| spi_miso | input | 1 | ROM data out; pulled down externally |
| mem_addr | output | 16 | Write address, bits 15..6 forced to one |
| mem_data | output | 8 | Write data |
| mem_wr | output | 1 | Write valid |
| mem_ready | input | 1 | Write ready from memory |
| load_done | output | 1 | Image fully loaded |
| cpu_bus_en | output | 1 | Processor bus enable, low while loading |

## Verification
spi_cs_n falls one clock after the edge that samples start. The first rising spi_sclk comes DIV clocks later, and each following edge of spi_sclk comes DIV clocks after the previous one. mem_wr rises in the clock after the spi_sclk rising edge that brings the frame flag to the head of the chain. The transfer completes on the first edge where mem_ready is high, and load_done follows on that same edge for the end pair. The bench samples on falling system clock edges and logs every accepted transfer in order. It checks the order of writes and the serial clock period from these logs rather than from fixed cycle offsets. It checks fixed-cycle values only for the reset state, the chip select response to start, and the quiet state after completion.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;

  localparam int OPC_W  = 8;
  localparam int RADR_W = 24;
  localparam int HDR_W  = OPC_W + RADR_W;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CW'(DIV - 1));
  assign rise = wrap && !sclk;
  assign fall = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdr_sender.sv
module hdr_sender #(
  parameter int HDR_W = 32,
  parameter logic [HDR_W-1:0] HDR = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fall,
  output logic mosi
);
  localparam int LW = $clog2(HDR_W + 1);

  logic [HDR_W-1:0] sr;
  logic [LW-1:0]    left;
  logic             busy;

  // down counter halts at zero; it gates its own shifting
  assign busy = (left != '0);
  assign mosi = busy && sr[HDR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= HDR;
      left <= LW'(HDR_W);
    end else if (fall && busy) begin
      sr   <= {sr[HDR_W-2:0], 1'b0};
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/pair_shifter.sv
module pair_shifter #(
  parameter int PAIR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift,
  input  logic              din,
  output logic [PAIR_W-1:0] pair
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair <= '0;
    end else if (clr) begin
      pair <= '0;
    end else if (shift) begin
      pair <= {pair[PAIR_W-2:0], din};
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int          DIV      = 2,
  parameter logic [7:0]  READ_CMD = 8'h03,
  parameter logic [23:0] ROM_BASE = 24'h000000,
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 8,
  parameter int          LOW_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_wr,
  input  logic              mem_ready,
  output logic              load_done,
  output logic              cpu_bus_en
);
  localparam int PAIR_W  = 2 * DATA_W;
  localparam int HI_BITS = ADDR_W - LOW_BITS;
  localparam int MARK_B  = PAIR_W - 1;
  localparam int END_B   = PAIR_W - 2;

  ld_state_e         state;
  logic [PAIR_W-1:0] pair;
  logic              marker, last, start_ok, accept, run_clk, clk_clr;
  logic              rise, fall;

  assign marker   = pair[MARK_B];
  assign last     = pair[END_B];
  assign start_ok = (state == LD_IDLE) && start;
  assign mem_wr   = (state == LD_RUN) && marker;
  assign accept   = mem_wr && mem_ready;
  assign run_clk  = (state == LD_RUN) && !marker;
  assign clk_clr  = (state != LD_RUN) || (accept && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LD_IDLE;
    end else begin
      case (state)
        LD_IDLE: if (start) state <= LD_RUN;
        LD_RUN:  if (accept && last) state <= LD_DONE;
        default: state <= state;
      endcase
    end
  end

  sclk_gen #(.DIV(DIV)) i_sclk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clk_clr),
    .run  (run_clk),
    .sclk (spi_sclk),
    .rise (rise),
    .fall (fall)
  );

  hdr_sender #(.HDR_W(HDR_W), .HDR({READ_CMD, ROM_BASE})) i_hdr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (start_ok),
    .fall (fall),
    .mosi (spi_mosi)
  );

  pair_shifter #(.PAIR_W(PAIR_W)) i_pair (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_ok || accept),
    .shift(rise),
    .din  (spi_miso),
    .pair (pair)
  );

  assign spi_cs_n   = (state != LD_RUN);
  assign mem_addr   = {{HI_BITS{1'b1}}, pair[DATA_W +: LOW_BITS]};
  assign mem_data   = pair[DATA_W-1:0];
  assign load_done  = (state == LD_DONE);
  assign cpu_bus_en = (state == LD_DONE);
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              spi_mosi,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic              load_done,
  input logic              cpu_bus_en
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_data)));

  p_sclk_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> $stable(spi_sclk));

  p_mosi_mode0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  p_wr_selected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !spi_cs_n);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (spi_cs_n && !spi_sclk && !mem_wr && cpu_bus_en));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
endmodule

bind boot_loader boot_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_wr    (mem_wr),
  .mem_ready (mem_ready),
  .load_done (load_done),
  .cpu_bus_en(cpu_bus_en)
);

// File: tb/test_boot_loader.sv
module test_boot_loader;
  localparam logic [23:0] BASE = 24'h012345;
  localparam logic [31:0] EXP_HDR = {8'h03, BASE};
  localparam int DIVV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic mem_wr;
  logic mem_ready = 1'b1;
  logic load_done, cpu_bus_en;

  always #10 clk = ~clk;

  boot_loader #(.DIV(DIVV), .ROM_BASE(BASE)) i_boot_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_wr(mem_wr), .mem_ready(mem_ready),
    .load_done(load_done), .cpu_bus_en(cpu_bus_en)
  );

  int n_chk = 0;
  int n_err = 0;

  logic stream [0:4095];
  int   slen = 0;
  logic [15:0] exp_a [0:127];
  logic [7:0]  exp_d [0:127];
  int   exp_n = 0;

  // ROM model and bus monitor, sampled on the system clock
  logic        prev_sclk = 1'b0;
  int          rises = 0, falls = 0, tot_rise = 0, cyc = 0, r1_cyc = 0, r2_cyc = 0;
  logic [31:0] hdr_cap = '0;
  int          mosi_bad = 0;
  logic [15:0] wr_a [0:127];
  logic [7:0]  wr_d [0:127];
  int          wr_cnt = 0, stall_cnt = 0;
  logic        stall_mode = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_sclk <= spi_sclk;
    if (!rst_n) begin
      tot_rise <= 0; mosi_bad <= 0; wr_cnt <= 0; stall_cnt <= 0;
    end else begin
      if (spi_sclk && !prev_sclk) tot_rise <= tot_rise + 1;
      if (mem_wr && mem_ready) begin
        if (wr_cnt < 128) begin
          wr_a[wr_cnt] <= mem_addr;
          wr_d[wr_cnt] <= mem_data;
        end
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_wr && !mem_ready) stall_cnt <= stall_cnt + 1;
    end
    if (spi_cs_n) begin
      rises <= 0; falls <= 0; spi_miso <= 1'b0;
    end else begin
      if (spi_sclk && !prev_sclk) begin
        if (rises < 32) hdr_cap <= {hdr_cap[30:0], spi_mosi};
        else if (spi_mosi) mosi_bad <= mosi_bad + 1;
        if (rises == 0) r1_cyc <= cyc;
        if (rises == 1) r2_cyc <= cyc;
        rises <= rises + 1;
      end
      if (!spi_sclk && prev_sclk) begin
        falls <= falls + 1;
        if (falls + 1 >= 32 && falls + 1 - 32 < slen) spi_miso <= stream[falls + 1 - 32];
        else spi_miso <= 1'b0;
      end
    end
  end

  always @(negedge clk) mem_ready <= stall_mode ? ((cyc % 3) == 2) : 1'b1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin stream[slen] = b[i]; slen++; end
  endtask

  task automatic push_zeros(input int n);
    for (int i = 0; i < n; i++) begin stream[slen] = 1'b0; slen++; end
  endtask

  task automatic push_pair(input logic [7:0] a, input logic [7:0] d, input logic counted);
    push_byte(a);
    push_byte(d);
    if (counted) begin
      exp_a[exp_n] = 16'hFFC0 | {10'd0, a[5:0]};
      exp_d[exp_n] = d;
      exp_n++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    slen = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit, input string tag);
    for (int k = 0; k < limit && !load_done; k++) @(negedge clk);
    chk(load_done, tag, {31'd0, load_done}, 32'd1);
  endtask

  task automatic check_writes(input string tag);
    chk(wr_cnt == exp_n, tag, wr_cnt, exp_n);
    for (int i = 0; i < exp_n && i < wr_cnt; i++) begin
      chk(wr_a[i] == exp_a[i], tag, {16'd0, wr_a[i]}, {16'd0, exp_a[i]});
      chk(wr_d[i] == exp_d[i], tag, {24'd0, wr_d[i]}, {24'd0, exp_d[i]});
    end
  endtask

  initial begin
    #2000000;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
    $finish;
  end

  initial begin
    int snap;
    int bad_hi;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 serial pins in reset", {spi_cs_n, spi_sclk}, 2'b10);
    chk(!mem_wr && !load_done && !cpu_bus_en, "R1 outputs in reset", {mem_wr, load_done, cpu_bus_en}, 3'b000);

    // Run A: full 64-byte sweep, permuted order, ready always high
    do_reset();
    repeat (5) @(negedge clk);
    chk(spi_cs_n && !spi_sclk && !load_done && !cpu_bus_en, "R1 idle before start",
        {spi_cs_n, spi_sclk, load_done, cpu_bus_en}, 4'b1000);
    push_zeros(13);
    for (int i = 0; i < 64; i++) begin
      logic [5:0] a;
      a = 6'((i * 37) % 64);
      push_pair(8'h80 | {2'b00, a}, 8'((a * 29 + 5) & 255), 1'b1);
    end
    push_pair(8'hC0, 8'h00, 1'b1);
    push_pair(8'h85, 8'hEE, 1'b0);
    pulse_start();
    chk(spi_cs_n == 1'b0, "R2 chip select after start", {31'd0, spi_cs_n}, 32'd0);
    repeat (500) @(negedge clk);
    pulse_start(); // R9: ignored while running
    wait_done(20000, "R8 run A done");
    chk(hdr_cap == EXP_HDR, "R2 opcode and address", hdr_cap, EXP_HDR);
    chk(mosi_bad == 0, "R2 mosi low after header", mosi_bad, 0);
    chk(r2_cyc - r1_cyc == 2 * DIVV, "R10 sclk period", r2_cyc - r1_cyc, 2 * DIVV);
    check_writes("R4 R7 R9 run A write sequence");
    bad_hi = 0;
    for (int i = 0; i < wr_cnt && i < 128; i++) if (wr_a[i][15:6] != 10'h3FF) bad_hi++;
    chk(bad_hi == 0, "R5 upper address bits", bad_hi, 0);
    chk(spi_cs_n && !spi_sclk && cpu_bus_en, "R8 released after end pair",
        {spi_cs_n, spi_sclk, cpu_bus_en}, 3'b101);
    snap = tot_rise;
    pulse_start(); // R9: ignored after completion
    repeat (60) @(negedge clk);
    chk(tot_rise == snap, "R8 R9 no sclk after done", tot_rise, snap);
    chk(spi_cs_n && load_done && wr_cnt == exp_n, "R8 R9 state holds after done",
        {spi_cs_n, load_done}, 2'b11);

    // Run B: back-pressure, irregular gaps, end pair with nonzero address
    do_reset();
    stall_mode = 1'b1;
    push_zeros(40);
    push_pair(8'h85, 8'h5A, 1'b1);
    push_zeros(3);
    push_pair(8'hBF, 8'hA5, 1'b1);
    push_zeros(11);
    push_pair(8'h92, 8'hFF, 1'b1);
    push_pair(8'hE1, 8'h77, 1'b1);
    push_pair(8'h90, 8'h11, 1'b0);
    pulse_start();
    wait_done(20000, "R8 run B done");
    chk(stall_cnt > 0, "R6 back-pressure seen", stall_cnt, 1);
    check_writes("R6 R7 R8 run B write sequence");
    chk(hdr_cap == EXP_HDR, "R2 header run B", hdr_cap, EXP_HDR);
    stall_mode = 1'b0;

    // Run C: idle all-zero line produces no write
    do_reset();
    pulse_start();
    repeat (800) @(negedge clk);
    chk(wr_cnt == 0, "R3 zero line no write", wr_cnt, 0);
    chk(!load_done && !spi_cs_n && !cpu_bus_en, "R3 still loading",
        {load_done, spi_cs_n, cpu_bus_en}, 3'b000);
    chk(tot_rise > 100, "R3 sclk keeps running", tot_rise, 101);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule